// File: doc/BRIEF.md
# Serial Register Access Target

This block lets an external serial host read and write a byte-wide register file inside the chip. Every transaction is a 24-bit frame sent while the select line is held low. The frame holds a direction bit, then a 15-bit register address, then one data byte. The serial clock, the select line and the serial input are brought into the core clock domain by synchronizers. All frame decoding therefore runs on the core clock `clk`. Each serial clock half-period must last at least four core clock cycles.

The register file is outside the block, behind a plain parallel port:
- an address bus,
- a write-data bus with a one-cycle write strobe,
- a combinational read-data return.

A static mode input chooses where read data goes:
- In shared-line mode, read data goes out on the same bidirectional data line that carries the host's bits. The block drives an output enable for that line.
- In separate-output mode, read data has its own serial output line, and the shared line only ever carries input.

Top module: `spi_reg_target`

## Requirements
- R1: A frame starts when `spi_cs_n` falls and ends when it rises. Raising `spi_cs_n` at any bit position discards the partial frame, and the next frame again starts with a direction bit.
- R2: Bits arrive most significant first and are sampled on rising `spi_sck` edges. Bit 0 of the frame is the direction (0 = write, 1 = read), bits 1..15 are address A14..A0, and bits 16..23 are data D7..D0.
- R3: In a write frame, the rising edge that samples D0 causes exactly one single-cycle `reg_wr` pulse before `spi_cs_n` rises. That pulse carries the frame's address on `reg_addr` and its data byte on `reg_wdata`.
- R4: A write frame that ends after fewer than 8 data bits produces no `reg_wr` pulse, and the addressed register keeps its value.
- R5: Serial clock edges after the 24th bit of a frame are ignored: they cause no further write and do not change the byte already committed.
- R6: In a read frame, `reg_addr` holds the full address once A0 has been sampled. The byte returned on `reg_rdata` is then driven out MSB first: D7 on the first falling edge after A0, and each later bit on the following falling edges. A host sampling on rising edges receives the register's value.
- R7: With `cfg_4wire` = 0, read data appears on `sdio_out` with `sdio_oe` high, and `spi_sdo` stays 0.
- R8: With `cfg_4wire` = 1, read data appears on `spi_sdo`, and `sdio_oe` is never asserted.
- R9: `sdio_oe` is asserted only in the data phase of a read frame, is never asserted during a write frame, and returns low within 4 `clk` cycles of `spi_cs_n` rising.
- R10: Right after reset, `sdio_oe`, `sdio_out`, `spi_sdo` and `reg_wr` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_4wire | input | 1 | 0: read data on shared line; 1: read data on `spi_sdo` |
| spi_cs_n | input | 1 | Frame select, active low |
| spi_sck | input | 1 | Serial clock from host |
| sdio_in | input | 1 | Shared data line, input side |
| sdio_out | output | 1 | Shared data line, output side |
| sdio_oe | output | 1 | Output enable for the shared line |
| spi_sdo | output | 1 | Dedicated serial read output |
| reg_addr | output | 15 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Register read data for `reg_addr` |

## Verification
A bit counter that drifts by one position shifts the decoded address and data. This shows up at the ports as a `reg_wr` carrying the wrong address or byte, or as a read byte rotated by one bit. Both are visible within the same frame. Select-abort and over-length frames confirm that the counter restarts cleanly. A stuck enable shows up as `sdio_oe` still high four cycles after the select rises. Enable wrongly asserted during write frames or in separate-output mode is caught by a per-clock monitor on the very cycle it occurs.

// File: rtl/spi_reg_pkg.sv
// Package: shared constants and the frame phase type for the serial
// register access target. Assumes a 1 + ADDR + DATA bit frame.
package spi_reg_pkg;

    localparam int DEF_ADDR_W   = 15;
    localparam int DEF_DATA_W   = 8;
    localparam int DEF_SYNC_LEN = 2;

    // Phase of the frame being received.
    typedef enum logic [1:0] {
        PH_DIR  = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_DONE = 2'd3
    } frame_phase_e;

endpackage

// File: rtl/spi_bit_sync.sv
// Module: multi-stage synchronizer for one asynchronous input bit.
// Assumes STAGES >= 1; RST_VAL is the value loaded by synchronous reset.
module spi_bit_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic stage_q;
        if (s == 0) begin : g_first
            // First stage captures the asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= RST_VAL;
                else        stage_q <= async_in;
            end
        end else begin : g_next
            // Later stages settle the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= RST_VAL;
                else        stage_q <= g_stage[s-1].stage_q;
            end
        end
    end

    assign sync_out = g_stage[STAGES-1].stage_q;

endmodule

// File: rtl/spi_frame_ctrl.sv
// Module: frame decoder. Detects serial clock edges, counts bits, collects
// direction, address and data, emits the write strobe and the read-fetch
// request, and indicates which data bit to drive on each falling edge.
// Assumes synchronized inputs and a frame that is active while cs_act is high.
module spi_frame_ctrl
    import spi_reg_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W,
    parameter int FRAME_BITS = 1 + ADDR_W + DATA_W,
    parameter int CNT_W = $clog2(FRAME_BITS + 1),
    parameter int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sck_s,
    input  logic              din_s,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              wr_pulse,
    output logic              fetch_req,
    output logic              frame_rd,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              tx_strobe,
    output logic [IDX_W-1:0]  tx_idx
);

    localparam logic [CNT_W-1:0] LAST_ADDR_CNT = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] FIRST_TX_CNT  = CNT_W'(ADDR_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT_CNT  = CNT_W'(FRAME_BITS - 1);

    frame_phase_e      phase_q;
    logic              sck_prev_q;
    logic [DATA_W-1:0] shift_q;
    logic              sck_rise;
    logic              sck_fall;

    // Keep the last synchronized clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev_q <= 1'b0;
        else        sck_prev_q <= sck_s;
    end

    assign sck_rise = sck_s & ~sck_prev_q;
    assign sck_fall = ~sck_s & sck_prev_q;

    // Frame state machine and bit collection on rising serial clock edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_DIR;
            bit_cnt   <= '0;
            frame_rd  <= 1'b0;
            addr_q    <= '0;
            shift_q   <= '0;
            wdata_q   <= '0;
            wr_pulse  <= 1'b0;
            fetch_req <= 1'b0;
        end else if (!cs_act) begin
            phase_q   <= PH_DIR;
            bit_cnt   <= '0;
            wr_pulse  <= 1'b0;
            fetch_req <= 1'b0;
        end else begin
            wr_pulse  <= 1'b0;
            fetch_req <= 1'b0;
            if (sck_rise && phase_q != PH_DONE) begin
                bit_cnt <= bit_cnt + 1'b1;
                unique case (phase_q)
                    PH_DIR: begin
                        frame_rd <= din_s;
                        phase_q  <= PH_ADDR;
                    end
                    PH_ADDR: begin
                        addr_q <= {addr_q[ADDR_W-2:0], din_s};
                        if (bit_cnt == LAST_ADDR_CNT) begin
                            phase_q   <= PH_DATA;
                            fetch_req <= frame_rd;
                        end
                    end
                    PH_DATA: begin
                        shift_q <= {shift_q[DATA_W-2:0], din_s};
                        if (bit_cnt == LAST_BIT_CNT) begin
                            phase_q  <= PH_DONE;
                            wr_pulse <= ~frame_rd;
                            wdata_q  <= {shift_q[DATA_W-2:0], din_s};
                        end
                    end
                    default: phase_q <= PH_DONE;
                endcase
            end
        end
    end

    // Falling edges inside the read data phase each select one data bit.
    always_comb begin
        tx_strobe = cs_act && sck_fall && frame_rd &&
                    (bit_cnt >= FIRST_TX_CNT) && (bit_cnt <= LAST_BIT_CNT);
        tx_idx    = IDX_W'(LAST_BIT_CNT - bit_cnt);
    end

endmodule

// File: rtl/spi_tx_path.sv
// Module: read return path. Captures the fetched register byte, drives one
// bit per selected falling edge and routes it to the shared line or the
// dedicated output by mode. Assumes the mode input is static during frames.
module spi_tx_path
    import spi_reg_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              four_wire,
    input  logic              fetch_req,
    input  logic [DATA_W-1:0] rdata,
    input  logic              tx_strobe,
    input  logic [IDX_W-1:0]  tx_idx,
    output logic              sdio_out,
    output logic              sdio_oe,
    output logic              sdo_out
);

    logic [DATA_W-1:0] tx_byte_q;
    logic              bit_q;
    logic              drive_q;

    // Hold the fetched byte and update the driven bit on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_byte_q <= '0;
            bit_q     <= 1'b0;
            drive_q   <= 1'b0;
        end else if (!cs_act) begin
            bit_q     <= 1'b0;
            drive_q   <= 1'b0;
        end else begin
            if (fetch_req) tx_byte_q <= rdata;
            if (tx_strobe) begin
                bit_q   <= tx_byte_q[tx_idx];
                drive_q <= 1'b1;
            end
        end
    end

    // Route the driven bit to the line chosen by the mode input.
    always_comb begin
        sdio_oe  = drive_q & ~four_wire;
        sdio_out = bit_q & ~four_wire;
        sdo_out  = bit_q & four_wire;
    end

endmodule

// File: rtl/spi_reg_target.sv
// Module: top of the serial register access target. Synchronizes the
// serial pins to clk, decodes 24-bit frames and exposes a parallel
// register port. Assumes each serial clock half-period lasts >= 4 clk cycles.
module spi_reg_target
    import spi_reg_pkg::*;
#(
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int DATA_W   = DEF_DATA_W,
    parameter int SYNC_LEN = DEF_SYNC_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_4wire,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              sdio_in,
    output logic              sdio_out,
    output logic              sdio_oe,
    output logic              spi_sdo,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr,
    input  logic [DATA_W-1:0] reg_rdata
);

    localparam int FRAME_BITS = 1 + ADDR_W + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int IDX_W      = $clog2(DATA_W);

    logic             cs_n_s;
    logic             sck_s;
    logic             din_s;
    logic             cs_act;
    logic             fetch_req;
    logic             frame_rd;
    logic [CNT_W-1:0] bit_cnt;
    logic             tx_strobe;
    logic [IDX_W-1:0] tx_idx;

    spi_bit_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b1)) i_sync_cs (
        .clk(clk), .rst_n(rst_n), .async_in(spi_cs_n), .sync_out(cs_n_s)
    );
    spi_bit_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b0)) i_sync_sck (
        .clk(clk), .rst_n(rst_n), .async_in(spi_sck), .sync_out(sck_s)
    );
    spi_bit_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b0)) i_sync_din (
        .clk(clk), .rst_n(rst_n), .async_in(sdio_in), .sync_out(din_s)
    );

    assign cs_act = ~cs_n_s;

    spi_frame_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAME_BITS(FRAME_BITS),
        .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) i_frame (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_s(sck_s),
        .din_s(din_s), .addr_q(reg_addr), .wdata_q(reg_wdata),
        .wr_pulse(reg_wr), .fetch_req(fetch_req), .frame_rd(frame_rd),
        .bit_cnt(bit_cnt), .tx_strobe(tx_strobe), .tx_idx(tx_idx)
    );

    spi_tx_path #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_tx (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .four_wire(cfg_4wire),
        .fetch_req(fetch_req), .rdata(reg_rdata), .tx_strobe(tx_strobe),
        .tx_idx(tx_idx), .sdio_out(sdio_out), .sdio_oe(sdio_oe),
        .sdo_out(spi_sdo)
    );

endmodule

// File: rtl/spi_reg_target_chk.sv
// Module: property checker for spi_reg_target, attached by bind.
// Assumes the internal names cs_act, bit_cnt and frame_rd in the top.
module spi_reg_target_chk #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter int FRAME_BITS = 1 + ADDR_W + DATA_W,
    parameter int CNT_W = $clog2(FRAME_BITS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_act,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic              frame_rd,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              sdio_oe
);

    AST_WR_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> cs_act);  // R1

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> bit_cnt == '0);  // R1

    AST_WR_NOT_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> !frame_rd);  // R2

    AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);  // R3

    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(FRAME_BITS));  // R5

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && $past(cs_act) && bit_cnt > CNT_W'(ADDR_W + 1))
        |-> $stable(reg_addr));  // R6

    AST_OE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !sdio_oe);  // R9

endmodule

bind spi_reg_target spi_reg_target_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .bit_cnt(bit_cnt),
    .frame_rd(frame_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .sdio_oe(sdio_oe)
);

// File: tb/test_spi_reg_target.sv
`timescale 1ns/1ps
// Bench: host-side serial driver, a behavioural register file, an expected
// write queue checked on every clock, and read-back comparisons.
module test_spi_reg_target;

    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_4wire = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_sck = 1'b0;
    logic        sdio_in = 1'b0;
    logic        sdio_out, sdio_oe, spi_sdo, reg_wr;
    logic [14:0] reg_addr;
    logic [7:0]  reg_wdata, reg_rdata;

    int checks = 0;
    int failures = 0;
    bit in_write = 1'b0;
    bit finished = 1'b0;

    logic [7:0]  bmem [64];
    logic [7:0]  exp_mem [64];
    logic [22:0] exp_q [$];

    always #2 clk = ~clk;

    spi_reg_target i_spi_reg_target (
        .clk(clk), .rst_n(rst_n), .cfg_4wire(cfg_4wire), .spi_cs_n(spi_cs_n),
        .spi_sck(spi_sck), .sdio_in(sdio_in), .sdio_out(sdio_out),
        .sdio_oe(sdio_oe), .spi_sdo(spi_sdo), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rdata(reg_rdata)
    );

    assign reg_rdata = bmem[reg_addr[5:0]];

    always @(posedge clk) if (rst_n && reg_wr) bmem[reg_addr[5:0]] <= reg_wdata;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
        $finish;
    endtask

    // Per-clock monitor: writes must match the expected queue, enable rules.
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_wr) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3/R4/R5 unexpected write", {reg_addr, reg_wdata}, 0);
                end else begin
                    logic [22:0] e;
                    e = exp_q.pop_front();
                    check({reg_addr, reg_wdata} == e, "R3 write addr/data",
                          {reg_addr, reg_wdata}, e);
                end
            end
            if (sdio_oe && cfg_4wire) check(1'b0, "R8 oe in 4-wire", 1, 0);
            if (sdio_oe && in_write)  check(1'b0, "R9 oe in write frame", 1, 0);
        end
    end

    // One host frame; nbits may be short (abort) or long (extra clocks).
    task automatic xfer(input bit rd, input logic [14:0] a, input logic [7:0] d,
                        input int nbits, output logic [7:0] got);
        logic [23:0] frame;
        bit oe_ok;
        frame = {rd, a, d};
        got = 8'h00;
        oe_ok = 1'b1;
        in_write = !rd;
        if (!rd && nbits >= 24) begin
            exp_q.push_back({a, d});
            exp_mem[a[5:0]] = d;
        end
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            spi_sck = 1'b0;
            sdio_in = (i < 24) ? frame[23-i] : 1'b1;
            repeat (HALF) @(negedge clk);
            if (rd && i >= 16 && i < 24) begin
                if (cfg_4wire) begin
                    got[23-i] = spi_sdo;
                    if (sdio_oe) oe_ok = 1'b0;
                end else begin
                    got[23-i] = sdio_out;
                    if (!sdio_oe || spi_sdo) oe_ok = 1'b0;
                end
            end
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        spi_sck = 1'b0;
        repeat (HALF) @(negedge clk);
        if (rd && nbits >= 24)
            check(oe_ok, cfg_4wire ? "R8 line routing" : "R7 line routing", oe_ok, 1);
        if (!rd) check(exp_q.size() == 0, "R3 write before cs high", exp_q.size(), 0);
        spi_cs_n = 1'b1;
        repeat (4) @(negedge clk);
        check(sdio_oe == 1'b0, "R9 oe released", sdio_oe, 0);
        in_write = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic read_check(input logic [14:0] a, input string req);
        logic [7:0] got;
        xfer(1'b1, a, 8'h00, 24, got);
        check(got == exp_mem[a[5:0]], req, got, exp_mem[a[5:0]]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog expired actual=hung expected=done");
        summary();
    end

    initial begin
        logic [7:0] dummy;
        for (int i = 0; i < 64; i++) begin
            bmem[i] = 8'(i * 7 + 3);
            exp_mem[i] = 8'(i * 7 + 3);
        end
        repeat (5) @(negedge clk);
        check(sdio_oe == 0, "R10 oe reset", sdio_oe, 0);
        check(sdio_out == 0, "R10 sdio_out reset", sdio_out, 0);
        check(spi_sdo == 0, "R10 sdo reset", spi_sdo, 0);
        check(reg_wr == 0, "R10 wr reset", reg_wr, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // 3-wire mode: writes then reads (R2, R3, R6, R7).
        xfer(1'b0, 15'h1234, 8'hA5, 24, dummy);
        xfer(1'b0, 15'h7FC1, 8'h3C, 24, dummy);
        read_check(15'h1234, "R6 read written A5");
        read_check(15'h7FC1, "R2 read written 3C");
        read_check(15'h000A, "R6 read untouched reg");

        // Partial byte dropped (R4).
        xfer(1'b0, 15'h0005, 8'hFF, 20, dummy);
        read_check(15'h0005, "R4 partial write discarded");

        // Extra clocks after bit 24 ignored (R5).
        xfer(1'b0, 15'h0006, 8'h81, 30, dummy);
        read_check(15'h0006, "R5 over-long frame single commit");

        // Abort mid-address, next frame clean (R1).
        xfer(1'b1, 15'h5555, 8'h00, 10, dummy);
        xfer(1'b0, 15'h0011, 8'h5A, 24, dummy);
        read_check(15'h0011, "R1 frame after abort");

        // 4-wire mode (R8).
        cfg_4wire = 1'b1;
        read_check(15'h1234, "R8 read on sdo");
        xfer(1'b0, 15'h0022, 8'hC3, 24, dummy);
        read_check(15'h0022, "R8 write then read");
        cfg_4wire = 1'b0;
        read_check(15'h0022, "R7 back to 3-wire");

        check(exp_q.size() == 0, "R3 all writes seen", exp_q.size(), 0);
        summary();
    end

endmodule